// File: doc/BRIEF.md
# Cascadable Unsigned Magnitude Comparator

This block compares two unsigned words and reports which one is larger, or that they are equal. It uses three separate flags. The work is done by 4-bit comparator slices. Each slice also accepts a lower-order verdict through three cascade inputs, so any operand width can be covered by chaining slices. The block is purely combinational and has no clock or storage.

The top level takes a width parameter and works out how many slices it needs. It pads both operands with zeros at the top up to the next multiple of four bits. The bottom slice has its cascade inputs tied to the "equal" verdict. Each slice first resolves its own nibble, starting from the most significant bit pair. It forwards the verdict from below only when all four of its own bit pairs match.

Top module: `mag_cmp_chain`

## Requirements
- R1: For any known pair of operands, exactly one of `lt_o`, `eq_o`, `gt_o` is high.
- R2: `gt_o` is high exactly when `a_i` is greater than `b_i`, read as unsigned integers.
- R3: `eq_o` is high exactly when `a_i` equals `b_i` in every bit.
- R4: `lt_o` is high exactly when `a_i` is less than `b_i`, read as unsigned integers.
- R5: The most significant unequal bit pair decides the verdict, whatever the bits below it are. For example, with 16-bit operands, A=0x8000 and B=0x7FFF give `gt_o`=1.
- R6: A slice whose four bit pairs are all equal passes on the verdict of the slice below it. For example, with 16-bit operands, A=0x1230 and B=0x1231 give `lt_o`=1.
- R7: A width that is not a multiple of four works over its full range. The padding bits never affect the result. The 7-bit case uses two slices and every input pair is correct.
- R8: A single-bit width uses one slice whose cascade inputs are tied to the equal verdict. It gives `eq_o` for equal bits and the correct ordering otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A, unsigned |
| b_i | input | WIDTH | Operand B, unsigned |
| lt_o | output | 1 | A is less than B |
| eq_o | output | 1 | A equals B |
| gt_o | output | 1 | A is greater than B |

## Verification
Two functions can act on the same result at once: a slice's own nibble decision, and the cascade verdict forwarded from the slice below it. Both are exercised by operand pairs whose upper nibbles are equal while a lower nibble differs, and by pairs whose upper nibbles differ in the opposite direction to the lower ones. The correct result is that the lower verdict wins only in the first case. The bench judges every output triple against a plain integer comparison of the operands. This covers every input pair at widths 1, 4 and 7, random pairs at width 16, and directed boundary pairs.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  typedef struct packed {
    logic lt;
    logic eq;
    logic gt;
  } rel_t;

  localparam rel_t REL_EQUAL = '{lt: 1'b0, eq: 1'b1, gt: 1'b0};
  localparam int unsigned SLICE_W = 4;
endpackage

// File: rtl/cmp_bit_rel.sv
module cmp_bit_rel (
  input  logic a_i,
  input  logic b_i,
  output logic same_o,
  output logic above_o,
  output logic below_o
);
  always_comb begin
    same_o  = ~(a_i ^ b_i);
    above_o = a_i & ~b_i;
    below_o = ~a_i & b_i;
  end
endmodule

// File: rtl/cmp_slice4.sv
module cmp_slice4
  import cmp_pkg::*;
#(
  parameter int unsigned SW = SLICE_W
) (
  input  logic [SW-1:0] a_i,
  input  logic [SW-1:0] b_i,
  input  rel_t          cas_i,
  output rel_t          rel_o
);
  logic [SW-1:0] same, above, below;

  generate
    for (genvar k = 0; k < SW; k++) begin : g_bit
      cmp_bit_rel u_bit (
        .a_i    (a_i[k]),
        .b_i    (b_i[k]),
        .same_o (same[k]),
        .above_o(above[k]),
        .below_o(below[k])
      );
    end
  endgenerate

  always_comb begin
    logic higher_same;
    logic gt_local, lt_local;
    higher_same = 1'b1;
    gt_local    = 1'b0;
    lt_local    = 1'b0;
    for (int k = SW - 1; k >= 0; k--) begin
      gt_local    = gt_local | (higher_same & above[k]);
      lt_local    = lt_local | (higher_same & below[k]);
      higher_same = higher_same & same[k];
    end
    rel_o.gt = gt_local | (higher_same & cas_i.gt);
    rel_o.lt = lt_local | (higher_same & cas_i.lt);
    rel_o.eq = higher_same & cas_i.eq;
  end
endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
  import cmp_pkg::*;
#(
  parameter int unsigned WIDTH = 7
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             lt_o,
  output logic             eq_o,
  output logic             gt_o
);
  localparam int unsigned NSL = (WIDTH + SLICE_W - 1) / SLICE_W;
  localparam int unsigned PW  = NSL * SLICE_W;

  logic [PW-1:0] a_pad, b_pad;
  rel_t          link [NSL+1];

  always_comb begin
    a_pad = '0;
    b_pad = '0;
    a_pad[WIDTH-1:0] = a_i;
    b_pad[WIDTH-1:0] = b_i;
  end

  assign link[0] = REL_EQUAL;

  generate
    for (genvar s = 0; s < NSL; s++) begin : g_slice
      cmp_slice4 #(.SW(SLICE_W)) u_slice (
        .a_i  (a_pad[s*SLICE_W +: SLICE_W]),
        .b_i  (b_pad[s*SLICE_W +: SLICE_W]),
        .cas_i(link[s]),
        .rel_o(link[s+1])
      );
    end
  endgenerate

  assign lt_o = link[NSL].lt;
  assign eq_o = link[NSL].eq;
  assign gt_o = link[NSL].gt;
endmodule

// File: rtl/mag_cmp_chain_chk.sv
module mag_cmp_chain_chk #(
  parameter int unsigned WIDTH = 7
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             lt_o,
  input logic             eq_o,
  input logic             gt_o
);
  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      a_r1_one_flag: assert ($countones({lt_o, eq_o, gt_o}) == 1)
        else $error("R1 flags not one-hot");
      a_r2_greater: assert (gt_o == (a_i > b_i))
        else $error("R2 greater flag wrong");
      a_r3_equal: assert (eq_o == (a_i == b_i))
        else $error("R3 equal flag wrong");
      a_r4_less: assert (lt_o == (a_i < b_i))
        else $error("R4 less flag wrong");
    end
  end
endmodule

bind mag_cmp_chain mag_cmp_chain_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i (a_i),
  .b_i (b_i),
  .lt_o(lt_o),
  .eq_o(eq_o),
  .gt_o(gt_o)
);

// File: tb/mag_cmp_chain_test.sv
module mag_cmp_chain_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [6:0]  a7 = '0, b7 = '0;
  logic [3:0]  a4 = '0, b4 = '0;
  logic [15:0] a16 = '0, b16 = '0;
  logic [0:0]  a1 = '0, b1 = '0;
  logic lt7, eq7, gt7, lt4, eq4, gt4, lt16, eq16, gt16, lt1, eq1, gt1;

  mag_cmp_chain #(.WIDTH(7))  uut  (.a_i(a7),  .b_i(b7),  .lt_o(lt7),  .eq_o(eq7),  .gt_o(gt7));
  mag_cmp_chain #(.WIDTH(4))  u_w4 (.a_i(a4),  .b_i(b4),  .lt_o(lt4),  .eq_o(eq4),  .gt_o(gt4));
  mag_cmp_chain #(.WIDTH(16)) u_w16(.a_i(a16), .b_i(b16), .lt_o(lt16), .eq_o(eq16), .gt_o(gt16));
  mag_cmp_chain #(.WIDTH(1))  u_w1 (.a_i(a1),  .b_i(b1),  .lt_o(lt1),  .eq_o(eq1),  .gt_o(gt1));

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // Encoding of a result triple: {gt, eq, lt}
  function automatic logic [2:0] ref_rel(longint unsigned x, longint unsigned y);
    if (x > y)       return 3'b100;
    else if (x == y) return 3'b010;
    else             return 3'b001;
  endfunction

  task automatic chk(string req, logic [2:0] act, logic [2:0] exp,
                     longint unsigned x, longint unsigned y);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s a=%0h b=%0h actual=%b expected=%b", req, x, y, act, exp);
    end
  endtask

  task automatic chk_onehot(string req, logic [2:0] act);
    n_chk++;
    if ($countones(act) != 1) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=one-hot", req, act);
    end
  endtask

  task automatic drive16(logic [15:0] x, logic [15:0] y);
    @(posedge clk); #1;
    a16 = x; b16 = y;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // reset state: all operands zero, so every instance reports equal (R3)
    chk("R3 reset w7",  {gt7, eq7, lt7},    3'b010, 0, 0);
    chk("R3 reset w16", {gt16, eq16, lt16}, 3'b010, 0, 0);

    // R5 top pair decides
    drive16(16'h8000, 16'h7FFF); @(negedge clk);
    chk("R5 msb decides", {gt16, eq16, lt16}, 3'b100, 16'h8000, 16'h7FFF);
    drive16(16'h0FFF, 16'h1000); @(negedge clk);
    chk("R5 msb decides low", {gt16, eq16, lt16}, 3'b001, 16'h0FFF, 16'h1000);
    // R6 forwarding through equal upper slices
    drive16(16'h1230, 16'h1231); @(negedge clk);
    chk("R6 forward lt", {gt16, eq16, lt16}, 3'b001, 16'h1230, 16'h1231);
    drive16(16'hABC9, 16'hABC2); @(negedge clk);
    chk("R6 forward gt", {gt16, eq16, lt16}, 3'b100, 16'hABC9, 16'hABC2);
    drive16(16'hFFFF, 16'hFFFF); @(negedge clk);
    chk("R3 all ones", {gt16, eq16, lt16}, 3'b010, 16'hFFFF, 16'hFFFF);
    drive16(16'h0001, 16'h0000); @(negedge clk);
    chk("R2 lsb only", {gt16, eq16, lt16}, 3'b100, 1, 0);

    // exhaustive 7/4/1-bit, random 16-bit
    for (int i = 0; i < 16384; i++) begin
      @(posedge clk); #1;
      a7 = i[13:7]; b7 = i[6:0];
      a4 = i[7:4];  b4 = i[3:0];
      a1 = i[1];    b1 = i[0];
      a16 = 16'($urandom); b16 = 16'($urandom);
      if (i[3]) b16[15:8] = a16[15:8];
      @(negedge clk);
      chk("R7 w7 R2 R3 R4", {gt7, eq7, lt7}, ref_rel(a7, b7), a7, b7);
      chk_onehot("R1 w7", {gt7, eq7, lt7});
      if (i < 256) chk("R2 R3 R4 w4", {gt4, eq4, lt4}, ref_rel(a4, b4), a4, b4);
      if (i < 4)   chk("R8 w1", {gt1, eq1, lt1}, ref_rel(a1, b1), a1, b1);
      if (i < 4000) begin
        chk("R2 R3 R4 R5 R6 w16", {gt16, eq16, lt16}, ref_rel(a16, b16), a16, b16);
        chk_onehot("R1 w16", {gt16, eq16, lt16});
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule